// File: doc/BRIEF.md
# Delayed Result Writeback Scheduler

This block models the stretch between execute and register-file writeback in a wide-issue datapath. Every functional-unit slot may hand over one issue record per clock. Each record carries a latency class, a destination register index and a result value that has already been computed. The result is then held back for the number of delay slots its class demands before it appears on that slot's register-file write port. As a result, a simple operation, a multiply, an older-style float multiply and a load all retire at different times, even though issue never stalls.

Each slot keeps an age-ordered delay line that is six stages deep. An entry retires from the stage whose age equals its class delay. After the delay lines, a port arbiter settles destination clashes between slots. A branch record writes nothing. When its five delay slots have passed, it raises a one-cycle redirect pulse. A hazard output tells the issue logic whether a queried register still has a result in flight.

Top module: `wbs_sched`

## Requirements
- R1: A record of class code 0 issued at clock edge k appears on its slot's write port, with its index and value, in the cycle right after edge k.
- R2: Class code 1 appears in the cycle after edge k+1, and class code 2 appears in the cycle after edge k+2.
- R3: Class code 3 (load) appears in the cycle after edge k+4.
- R4: Class code 4 (branch) never drives a write. It raises `redirect` for exactly one cycle, in the cycle after edge k+5.
- R5: `hazard` is high while any held non-branch entry, including one being written in the current cycle, targets `query_idx`. It is low otherwise.
- R6: If two slots write the same destination in the same cycle, only the higher-numbered slot's `wr_en` is high, and `collide` is high.
- R7: If two results from the same slot are due in the same cycle, only the later-issued one is written, the other is dropped, and `collide` is high.
- R8: Class codes 5 to 7 behave exactly like code 0.
- R9: A synchronous active-high `rst` drops every held entry. After it, no write and no redirect appear until new records are issued.
- R10: All slots may issue in the same cycle. Results with distinct destinations are all written in parallel on their own ports, with `collide` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | NUM_SLOTS | Issue record present, one bit per slot |
| iss_class | input | NUM_SLOTS*3 | Latency class code per slot |
| iss_dest | input | NUM_SLOTS*IDX_W | Destination register index per slot |
| iss_data | input | NUM_SLOTS*DATA_W | Precomputed result per slot |
| query_idx | input | IDX_W | Register index to test for a pending write |
| wr_en | output | NUM_SLOTS | Write enable per slot port |
| wr_idx | output | NUM_SLOTS*IDX_W | Write index per slot port |
| wr_data | output | NUM_SLOTS*DATA_W | Write value per slot port |
| collide | output | 1 | A write was suppressed in this cycle |
| redirect | output | 1 | Branch has taken effect |
| hazard | output | 1 | Queried register has a result in flight |

## Verification
A record that is sampled at edge k is due in the cycle after edge k+d. Here d is 0, 1, 2 or 4 for the writing classes, and 5 for the redirect. The bench drives inputs on the falling edge and clears them one falling edge later. It then counts falling edges, so the count at which a write first shows up is exactly d and can be compared with the table value. The redirect test scans the same window to confirm there is a single pulse at count 5. The reset test watches past the longest delay to confirm that nothing leaks out.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   localparam int CLS_W     = 3;
   localparam int MAX_DELAY = 5;

   typedef enum logic [CLS_W-1:0] {
      CLS_ALU      = 3'd0,
      CLS_MUL      = 3'd1,
      CLS_FMUL_OLD = 3'd2,
      CLS_LOAD     = 3'd3,
      CLS_BRANCH   = 3'd4
   } lat_class_e;

   // delay slots per class; unused codes fall back to zero (R8)
   function automatic logic [CLS_W-1:0] delay_of(input logic [CLS_W-1:0] c);
      case (c)
         CLS_MUL:      delay_of = 3'd1;
         CLS_FMUL_OLD: delay_of = 3'd2;
         CLS_LOAD:     delay_of = 3'd4;
         CLS_BRANCH:   delay_of = 3'd5;
         default:      delay_of = 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/wbs_delay_line.sv
module wbs_delay_line
   import wbs_pkg::*;
#(
   parameter int IDX_W  = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [CLS_W-1:0]  in_cls,
   input  logic [IDX_W-1:0]  in_dest,
   input  logic [DATA_W-1:0] in_data,
   input  logic [IDX_W-1:0]  query_idx,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_data,
   output logic              out_multi,
   output logic              out_branch,
   output logic              out_hazard
);
   localparam int DEPTH = MAX_DELAY + 1;

   logic [DEPTH-1:0]  v_q;
   logic [CLS_W-1:0]  cls_q [DEPTH];
   logic [IDX_W-1:0]  dst_q [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [DEPTH-1:0]  due;
   logic [DEPTH-1:0]  is_br;

   always_comb begin
      for (int a = 0; a < DEPTH; a++) begin
         is_br[a] = v_q[a] && (cls_q[a] == CLS_BRANCH);
         due[a]   = v_q[a] && (delay_of(cls_q[a]) == CLS_W'(a));
      end
   end

   // age-ordered line: stage a holds the record issued a edges ago
   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= '0;
      end else begin
         v_q[0] <= in_valid;
         for (int a = 1; a < DEPTH; a++)
            v_q[a] <= v_q[a-1] && !due[a-1];
      end
   end

   always_ff @(posedge clk) begin
      cls_q[0] <= in_cls;
      dst_q[0] <= in_dest;
      dat_q[0] <= in_data;
      for (int a = 1; a < DEPTH; a++) begin
         cls_q[a] <= cls_q[a-1];
         dst_q[a] <= dst_q[a-1];
         dat_q[a] <= dat_q[a-1];
      end
   end

   // oldest first, so the youngest due entry is the one left standing
   always_comb begin
      out_valid  = 1'b0;
      out_multi  = 1'b0;
      out_idx    = '0;
      out_data   = '0;
      out_branch = 1'b0;
      out_hazard = 1'b0;
      for (int a = DEPTH-1; a >= 0; a--) begin
         if (due[a] && !is_br[a]) begin
            out_multi = out_multi | out_valid;
            out_valid = 1'b1;
            out_idx   = dst_q[a];
            out_data  = dat_q[a];
         end
         if (due[a] && is_br[a])
            out_branch = 1'b1;
         if (v_q[a] && !is_br[a] && (dst_q[a] == query_idx))
            out_hazard = 1'b1;
      end
   end
endmodule

// File: rtl/wbs_port_arbiter.sv
module wbs_port_arbiter #(
   parameter int NUM_SLOTS = 8,
   parameter int IDX_W     = 5
) (
   input  logic [NUM_SLOTS-1:0]       cand_valid,
   input  logic [NUM_SLOTS*IDX_W-1:0] cand_idx,
   output logic [NUM_SLOTS-1:0]       grant,
   output logic                       cross_hit
);
   always_comb begin
      grant     = cand_valid;
      cross_hit = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         for (int t = s + 1; t < NUM_SLOTS; t++) begin
            if (cand_valid[s] && cand_valid[t] &&
                (cand_idx[s*IDX_W +: IDX_W] == cand_idx[t*IDX_W +: IDX_W])) begin
               grant[s]  = 1'b0;
               cross_hit = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wbs_sched.sv
module wbs_sched
   import wbs_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int IDX_W     = 5,
   parameter int DATA_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_SLOTS-1:0]        iss_valid,
   input  logic [NUM_SLOTS*CLS_W-1:0]  iss_class,
   input  logic [NUM_SLOTS*IDX_W-1:0]  iss_dest,
   input  logic [NUM_SLOTS*DATA_W-1:0] iss_data,
   input  logic [IDX_W-1:0]            query_idx,
   output logic [NUM_SLOTS-1:0]        wr_en,
   output logic [NUM_SLOTS*IDX_W-1:0]  wr_idx,
   output logic [NUM_SLOTS*DATA_W-1:0] wr_data,
   output logic                        collide,
   output logic                        redirect,
   output logic                        hazard
);
   if (NUM_SLOTS < 2 || NUM_SLOTS > 16) begin : g_bad_slots
      $error("wbs_sched: NUM_SLOTS must lie in 2..16");
   end
   if (IDX_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("wbs_sched: IDX_W and DATA_W must be positive");
   end

   logic [NUM_SLOTS-1:0] cand_valid;
   logic [NUM_SLOTS-1:0] multi;
   logic [NUM_SLOTS-1:0] br_due;
   logic [NUM_SLOTS-1:0] hz;
   logic                 cross_hit;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      wbs_delay_line #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_line (
         .clk        (clk),
         .rst        (rst),
         .in_valid   (iss_valid[s]),
         .in_cls     (iss_class[s*CLS_W +: CLS_W]),
         .in_dest    (iss_dest[s*IDX_W +: IDX_W]),
         .in_data    (iss_data[s*DATA_W +: DATA_W]),
         .query_idx  (query_idx),
         .out_valid  (cand_valid[s]),
         .out_idx    (wr_idx[s*IDX_W +: IDX_W]),
         .out_data   (wr_data[s*DATA_W +: DATA_W]),
         .out_multi  (multi[s]),
         .out_branch (br_due[s]),
         .out_hazard (hz[s])
      );
   end

   wbs_port_arbiter #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_arb (
      .cand_valid (cand_valid),
      .cand_idx   (wr_idx),
      .grant      (wr_en),
      .cross_hit  (cross_hit)
   );

   assign collide  = cross_hit | (|multi);
   assign redirect = |br_due;
   assign hazard   = |hz;
endmodule

// File: rtl/wbs_sched_chk.sv
module wbs_sched_chk
   import wbs_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int IDX_W     = 5,
   parameter int DATA_W    = 32
) (
   input logic                        clk,
   input logic                        rst,
   input logic [NUM_SLOTS-1:0]        iss_valid,
   input logic [NUM_SLOTS*CLS_W-1:0]  iss_class,
   input logic [NUM_SLOTS*IDX_W-1:0]  iss_dest,
   input logic [NUM_SLOTS*DATA_W-1:0] iss_data,
   input logic [IDX_W-1:0]            query_idx,
   input logic [NUM_SLOTS-1:0]        wr_en,
   input logic [NUM_SLOTS*IDX_W-1:0]  wr_idx,
   input logic [NUM_SLOTS*DATA_W-1:0] wr_data,
   input logic                        collide,
   input logic                        redirect,
   input logic                        hazard
);
   localparam int TOP = NUM_SLOTS - 1;
   localparam int SUB = NUM_SLOTS - 2;

   logic [2:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   logic alu_top, ld_top, any_br, dup_top;
   logic [IDX_W-1:0]  dst_top, wri_top;
   logic [DATA_W-1:0] dat_top, wrd_top;
   assign dst_top = iss_dest[TOP*IDX_W +: IDX_W];
   assign dat_top = iss_data[TOP*DATA_W +: DATA_W];
   assign wri_top = wr_idx[TOP*IDX_W +: IDX_W];
   assign wrd_top = wr_data[TOP*DATA_W +: DATA_W];
   assign alu_top = iss_valid[TOP] && iss_class[TOP*CLS_W +: CLS_W] == CLS_ALU;
   assign ld_top  = iss_valid[TOP] && iss_class[TOP*CLS_W +: CLS_W] == CLS_LOAD;
   assign dup_top = alu_top && iss_valid[SUB] &&
                    iss_class[SUB*CLS_W +: CLS_W] == CLS_ALU &&
                    iss_dest[SUB*IDX_W +: IDX_W] == dst_top;
   always_comb begin
      any_br = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (iss_valid[s] && iss_class[s*CLS_W +: CLS_W] == CLS_BRANCH) any_br = 1'b1;
   end

   a_r1_alu_next_cycle: assert property (@(posedge clk) disable iff (rst)
      alu_top |=> wr_en[TOP] && wri_top == $past(dst_top) && wrd_top == $past(dat_top));

   a_r3_load_four_slots: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 3'd5 && $past(ld_top, 5)) |->
         (wr_en[TOP] && wri_top == $past(dst_top, 5)) || collide);

   a_r4_branch_redirect: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 3'd6 && $past(any_br, 6)) |-> redirect);

   a_r4_redirect_source: assert property (@(posedge clk) disable iff (rst)
      redirect |-> since_rst >= 3'd6 && $past(any_br, 6));

   a_r5_hazard_on_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en[TOP] && wri_top == query_idx) |-> hazard);

   a_r6_high_slot_wins: assert property (@(posedge clk) disable iff (rst)
      dup_top |=> collide && wr_en[TOP] && !wr_en[SUB]);

   a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> wr_en == '0 && !redirect && !hazard);
endmodule

bind wbs_sched wbs_sched_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .IDX_W     (IDX_W),
   .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/tb_wbs_sched.sv
`timescale 1ns/1ps
module tb_wbs_sched;
   localparam int NS  = 8;
   localparam int IW  = 5;
   localparam int DW  = 32;
   localparam int TOP = NS - 1;

   logic            clk = 1'b0;
   logic            rst;
   logic [NS-1:0]   iss_valid;
   logic [NS*3-1:0] iss_class;
   logic [NS*IW-1:0] iss_dest;
   logic [NS*DW-1:0] iss_data;
   logic [IW-1:0]   query_idx;
   logic [NS-1:0]   wr_en;
   logic [NS*IW-1:0] wr_idx;
   logic [NS*DW-1:0] wr_data;
   logic            collide, redirect, hazard;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   wbs_sched #(.NUM_SLOTS(NS), .IDX_W(IW), .DATA_W(DW)) dut (.*);

   // {class, dest, value, expected delay}
   localparam logic [42:0] VEC [6] = '{
      {3'd0, 5'd3,  32'h0000_1111, 3'd0},   // R1
      {3'd1, 5'd4,  32'h0000_2222, 3'd1},   // R2
      {3'd2, 5'd5,  32'h0000_3333, 3'd2},   // R2
      {3'd3, 5'd6,  32'h0000_4444, 3'd4},   // R3
      {3'd5, 5'd8,  32'h0000_5555, 3'd0},   // R8
      {3'd7, 5'd11, 32'h0000_6666, 3'd0}    // R8
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      iss_valid = '0; iss_class = '0; iss_dest = '0; iss_data = '0;
   endtask

   task automatic put(input int s, input logic [2:0] c, input logic [IW-1:0] d,
                      input logic [DW-1:0] x);
      iss_valid[s] = 1'b1;
      iss_class[s*3 +: 3] = c;
      iss_dest[s*IW +: IW] = d;
      iss_data[s*DW +: DW] = x;
   endtask

   function automatic string tag(input logic [2:0] c);
      case (c)
         3'd0: tag = "R1";
         3'd1, 3'd2: tag = "R2";
         3'd3: tag = "R3";
         default: tag = "R8";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; clear_in(); query_idx = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      chk("R9 wr_en", 64'(wr_en), 0);
      chk("R9 redirect", 64'(redirect), 0);
      chk("R9 collide", 64'(collide), 0);
      chk("R9 hazard", 64'(hazard), 0);

      // table walk: latency per class
      for (int i = 0; i < 6; i++) begin
         logic [2:0] c; logic [IW-1:0] d; logic [DW-1:0] x; logic [2:0] e;
         int seen; logic [IW-1:0] gi; logic [DW-1:0] gd;
         {c, d, x, e} = VEC[i];
         put(TOP, c, d, x); query_idx = d;
         @(negedge clk);
         clear_in();
         seen = -1; gi = '0; gd = '0;
         for (int k = 0; k < 8; k++) begin
            if (k == 0) chk("R5 hazard in flight", 64'(hazard), 1);
            if (wr_en[TOP] && seen < 0) begin
               seen = k; gi = wr_idx[TOP*IW +: IW]; gd = wr_data[TOP*DW +: DW];
            end
            @(negedge clk);
         end
         chk({tag(c), " delay"}, 64'(seen), 64'(e));
         chk({tag(c), " index"}, 64'(gi), 64'(d));
         chk({tag(c), " value"}, 64'(gd), 64'(x));
      end

      // R10 all slots at once, distinct destinations
      for (int s = 0; s < NS; s++) put(s, 3'd0, IW'(s + 1), DW'(100 + s));
      @(negedge clk);
      clear_in();
      chk("R10 wr_en", 64'(wr_en), 64'({NS{1'b1}}));
      chk("R10 collide", 64'(collide), 0);
      for (int s = 0; s < NS; s++) begin
         chk("R10 index", 64'(wr_idx[s*IW +: IW]), 64'(s + 1));
         chk("R10 value", 64'(wr_data[s*DW +: DW]), 64'(100 + s));
      end
      @(negedge clk);

      // R6 cross-slot clash
      put(TOP, 3'd0, 5'd7, 32'hAA); put(TOP-1, 3'd0, 5'd7, 32'hBB);
      @(negedge clk);
      clear_in();
      chk("R6 high slot written", 64'(wr_en[TOP]), 1);
      chk("R6 low slot dropped", 64'(wr_en[TOP-1]), 0);
      chk("R6 value", 64'(wr_data[TOP*DW +: DW]), 64'hAA);
      chk("R6 collide", 64'(collide), 1);
      @(negedge clk);

      // R7 same-slot clash: multiply then simple op one cycle later
      put(0, 3'd1, 5'd9, 32'h11);
      @(negedge clk);
      clear_in();
      put(0, 3'd0, 5'd10, 32'h22);
      @(negedge clk);
      clear_in();
      chk("R7 written", 64'(wr_en[0]), 1);
      chk("R7 index", 64'(wr_idx[0 +: IW]), 10);
      chk("R7 value", 64'(wr_data[0 +: DW]), 64'h22);
      chk("R7 collide", 64'(collide), 1);
      @(negedge clk);
      chk("R7 older dropped", 64'(wr_en[0]), 0);
      repeat (2) @(negedge clk);

      // R4 branch: redirect pulse only
      begin
         int first; int cnt; logic wany;
         put(2, 3'd4, 5'd3, 32'h5A); query_idx = 5'd3;
         @(negedge clk);
         clear_in();
         first = -1; cnt = 0; wany = 1'b0;
         for (int k = 0; k < 8; k++) begin
            if (k == 0) chk("R5 branch not a hazard", 64'(hazard), 0);
            if (redirect) begin cnt++; if (first < 0) first = k; end
            if (wr_en != '0) wany = 1'b1;
            @(negedge clk);
         end
         chk("R4 redirect cycle", 64'(first), 5);
         chk("R4 redirect width", 64'(cnt), 1);
         chk("R4 no write", 64'(wany), 0);
      end

      // R5 hazard window of a load
      put(1, 3'd3, 5'd12, 32'h99); query_idx = 5'd12;
      @(negedge clk);
      clear_in();
      for (int k = 0; k < 6; k++) begin
         chk("R5 load hazard", 64'(hazard), (k <= 4) ? 1 : 0);
         if (k == 2) begin
            query_idx = 5'd13; #0.1;
            chk("R5 other register", 64'(hazard), 0);
            query_idx = 5'd12;
         end
         @(negedge clk);
      end

      // R9 reset flushes an in-flight load
      begin
         logic wany; logic hany;
         put(TOP, 3'd3, 5'd20, 32'h77); query_idx = 5'd20;
         @(negedge clk);
         clear_in();
         rst = 1'b1;
         @(negedge clk);
         rst = 1'b0;
         wany = 1'b0; hany = 1'b0;
         for (int k = 0; k < 7; k++) begin
            if (wr_en != '0) wany = 1'b1;
            if (hazard) hany = 1'b1;
            @(negedge clk);
         end
         chk("R9 no write after reset", 64'(wany), 0);
         chk("R9 no hazard after reset", 64'(hany), 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule